// File: doc/BRIEF.md
# Two-Way Read Cache with Snoop Invalidation

This block is a two-way set-associative cache that sits between a processor and one port of a shared memory controller. Processor reads that hit are answered from the cache arrays in the cycle of the request. Reads that miss fetch a whole four-word line from the memory port. Processor writes pass straight through to memory.

A second bus master writes the same memory through its own, uncached path. The cache sees each of those writes on a snoop input. Any cached line holding the written address is marked invalid, so the processor's next read of that address goes back to memory and never returns stale data. Snooped data is never copied into the cache.

Addresses are word addresses. With the default parameters, bits [1:0] select the word within a line, bits [5:2] select the set and bits [11:6] form the tag.

Top module: `snoop_cache`

## Requirements
- R1: After synchronous reset every line in both ways is invalid and `cpu_ready` and `mem_req` are low. The first read of any address therefore misses.
- R2: A read that hits raises `cpu_ready` combinationally in the same cycle as `cpu_req`, with the cached word on `cpu_rdata` and no memory request. `cpu_ready` is never high without `cpu_req`.
- R3: A read miss issues one memory request at the line base address (word bits [1:0] zero) and holds it steady. Four words are taken on four `mem_ack` beats in ascending word order. After the last beat the pending read is looked up again and hits in the following cycle.
- R4: Two lines with the same set index and different tags are held at once, one per way, and at most one way hits on any lookup.
- R5: On a miss the refilled way is an invalid way if the set has one (way 0 first). Otherwise it is the least recently used way. A read hit or a completed fill makes the other way the least recently used one.
- R6: A snooped write whose address falls in a valid cached line invalidates that line without changing its data. The next read of any word of that line misses and returns the current memory value.
- R7: A snooped write that matches no valid line leaves every cached line unchanged.
- R8: A snooped write that matches the line being filled, in any cycle from the one after the miss is accepted through the last beat, leaves that line invalid when the fill ends. The held read then fetches the line again.
- R9: When a snoop and a processor lookup occur in the same cycle, the invalidation is applied before the processor's hit decision.
- R10: A processor write sends address and data to memory with `mem_we` high and completes (`cpu_ready`) in the cycle of `mem_ack`. If the address hits, the cached word takes the new value.
- R11: A processor write that misses does not allocate a line.
- R12: Every completed processor read returns the value memory holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Request complete this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Memory request, held until the transfer ends |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address (line base for fills) |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Read beat or write completion from memory |
| mem_rdata | input | DW | Read beat data |
| snp_we | input | 1 | Second master writes memory this cycle |
| snp_addr | input | AW | Word address of the snooped write |

## Verification
A read hit is due combinationally in the request cycle. The bench drives inputs one time unit after a rising edge and samples on the following falling edge, so zero wait cycles means a hit. A miss completes one cycle after the fourth fill beat's edge. A write completes in the same cycle as `mem_ack`, so each task waits on `cpu_ready` at falling edges and counts the cycles it saw. On every falling edge the bench compares each completed read with a behavioural memory array that is updated at the clock edge where a snooped write or a memory write acknowledge lands. For the fill-snoop and same-cycle cases, the snoop is timed against the counted edges so that it falls inside the burst or on the lookup cycle.

// File: rtl/snoop_cache_pkg.sv
`timescale 1ns/1ps
package snoop_cache_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_FILL  = 2'd1,
        CS_WRITE = 2'd2
    } cache_state_e;

    // Replacement choice: an empty way first (way 0 before way 1), else the LRU way.
    function automatic logic pick_victim(input logic [1:0] live, input logic lru_way);
        if (!live[0]) return 1'b0;
        if (!live[1]) return 1'b1;
        return lru_way;
    endfunction

endpackage

// File: rtl/sc_tag_store.sv
`timescale 1ns/1ps
module sc_tag_store
    import snoop_cache_pkg::*;
#(
    parameter int IDXW = 4,
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] lk_idx,
    input  logic [TAGW-1:0] lk_tag,
    input  logic            sn_we,
    input  logic [IDXW-1:0] sn_idx,
    input  logic [TAGW-1:0] sn_tag,
    input  logic            touch_en,
    input  logic            touch_way,
    input  logic            alloc_en,
    input  logic            alloc_way,
    input  logic            fill_en,
    input  logic            fill_ok,
    input  logic [IDXW-1:0] fill_idx,
    input  logic            fill_way,
    output logic [1:0]      hit,
    output logic            victim
);
    localparam int SETS = 1 << IDXW;

    logic [SETS-1:0] vld_q [2];
    logic [TAGW-1:0] tag_q [2][SETS];
    logic [SETS-1:0] lru_q;
    logic [1:0]      sn_kill;
    logic [1:0]      live;

    // Snoop match is folded into the lookup valid bits so it wins in the same cycle.
    always_comb begin
        for (int w = 0; w < 2; w++) begin
            sn_kill[w] = sn_we && vld_q[w][sn_idx] && (tag_q[w][sn_idx] == sn_tag);
            live[w]    = vld_q[w][lk_idx] && !(sn_kill[w] && (sn_idx == lk_idx));
            hit[w]     = live[w] && (tag_q[w][lk_idx] == lk_tag);
        end
        victim = pick_victim(live, lru_q[lk_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q[0] <= '0;
            vld_q[1] <= '0;
            lru_q    <= '0;
        end else begin
            for (int w = 0; w < 2; w++) begin
                if (sn_kill[w]) vld_q[w][sn_idx] <= 1'b0;
            end
            if (alloc_en)           vld_q[alloc_way][lk_idx] <= 1'b0;
            if (fill_en && fill_ok) vld_q[fill_way][fill_idx] <= 1'b1;
            if (touch_en)           lru_q[lk_idx]   <= ~touch_way;
            if (fill_en)            lru_q[fill_idx] <= ~fill_way;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) tag_q[alloc_way][lk_idx] <= lk_tag;
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_way_chk
            AST_SNOOP_DROPS_LINE: assert property (@(posedge clk) disable iff (rst)
                sn_kill[g] |=> !vld_q[g][$past(sn_idx)]); // R6
        end
    endgenerate

    AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)); // R4

endmodule

// File: rtl/sc_data_store.sv
`timescale 1ns/1ps
module sc_data_store #(
    parameter int IDXW = 4,
    parameter int OFFW = 2,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic            wr_way,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [OFFW-1:0] wr_off,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_way,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [OFFW-1:0] rd_off,
    output logic [DW-1:0]   rd_data
);
    localparam int DEPTH = 2 << (IDXW + OFFW);

    logic [DW-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[{wr_way, wr_idx, wr_off}] <= wr_data;
    end

    assign rd_data = word_q[{rd_way, rd_idx, rd_off}];

endmodule

// File: rtl/snoop_cache.sv
`timescale 1ns/1ps
module snoop_cache
    import snoop_cache_pkg::*;
#(
    parameter int AW   = 12,
    parameter int IDXW = 4,
    parameter int OFFW = 2,
    parameter int DW   = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr
);
    localparam int TAGW = AW - IDXW - OFFW;

    typedef struct packed {
        logic [TAGW-1:0] tag;
        logic [IDXW-1:0] idx;
        logic [OFFW-1:0] off;
    } waddr_t;

    waddr_t          cpu_a, snp_a;
    cache_state_e    state_q;
    logic [TAGW-1:0] fill_tag_q;
    logic [IDXW-1:0] fill_idx_q;
    logic            fill_way_q;
    logic [OFFW-1:0] beat_q;
    logic            fill_dead_q;
    logic [AW-1:0]   wr_addr_q;
    logic [DW-1:0]   wr_data_q;

    logic [1:0]      hit;
    logic            victim, any_hit, hit_way;
    logic            idle_take, sn_on_fill, last_beat;
    logic            dwr_en, dwr_way;
    logic [IDXW-1:0] dwr_idx;
    logic [OFFW-1:0] dwr_off;
    logic [DW-1:0]   dwr_data;
    logic            unused_snp_off;

    assign cpu_a          = waddr_t'(cpu_addr);
    assign snp_a          = waddr_t'(snp_addr);
    assign unused_snp_off = ^snp_a.off;
    assign any_hit        = |hit;
    assign hit_way        = hit[1];
    assign idle_take      = (state_q == CS_IDLE) && cpu_req;
    assign sn_on_fill     = snp_we && (snp_a.idx == fill_idx_q) && (snp_a.tag == fill_tag_q);
    assign last_beat      = (state_q == CS_FILL) && mem_ack && (&beat_q);

    sc_tag_store #(.IDXW(IDXW), .TAGW(TAGW)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (cpu_a.idx),
        .lk_tag    (cpu_a.tag),
        .sn_we     (snp_we),
        .sn_idx    (snp_a.idx),
        .sn_tag    (snp_a.tag),
        .touch_en  (idle_take && !cpu_we && any_hit),
        .touch_way (hit_way),
        .alloc_en  (idle_take && !cpu_we && !any_hit),
        .alloc_way (victim),
        .fill_en   (last_beat),
        .fill_ok   (!fill_dead_q && !sn_on_fill),
        .fill_idx  (fill_idx_q),
        .fill_way  (fill_way_q),
        .hit       (hit),
        .victim    (victim)
    );

    // One write port: fill beats in FILL, write-through hits in IDLE.
    always_comb begin
        if (state_q == CS_FILL) begin
            dwr_en   = mem_ack;
            dwr_way  = fill_way_q;
            dwr_idx  = fill_idx_q;
            dwr_off  = beat_q;
            dwr_data = mem_rdata;
        end else begin
            dwr_en   = idle_take && cpu_we && any_hit;
            dwr_way  = hit_way;
            dwr_idx  = cpu_a.idx;
            dwr_off  = cpu_a.off;
            dwr_data = cpu_wdata;
        end
    end

    sc_data_store #(.IDXW(IDXW), .OFFW(OFFW), .DW(DW)) u_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_way  (dwr_way),
        .wr_idx  (dwr_idx),
        .wr_off  (dwr_off),
        .wr_data (dwr_data),
        .rd_way  (hit_way),
        .rd_idx  (cpu_a.idx),
        .rd_off  (cpu_a.off),
        .rd_data (cpu_rdata)
    );

    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            CS_IDLE:  cpu_ready = cpu_req && !cpu_we && any_hit;
            CS_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {fill_tag_q, fill_idx_q, {OFFW{1'b0}}};
            end
            CS_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_addr_q;
                mem_wdata = wr_data_q;
                cpu_ready = mem_ack;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CS_IDLE;
            fill_tag_q  <= '0;
            fill_idx_q  <= '0;
            fill_way_q  <= 1'b0;
            beat_q      <= '0;
            fill_dead_q <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
        end else begin
            case (state_q)
                CS_IDLE: begin
                    if (cpu_req && cpu_we) begin
                        state_q   <= CS_WRITE;
                        wr_addr_q <= cpu_addr;
                        wr_data_q <= cpu_wdata;
                    end else if (cpu_req && !any_hit) begin
                        state_q     <= CS_FILL;
                        fill_tag_q  <= cpu_a.tag;
                        fill_idx_q  <= cpu_a.idx;
                        fill_way_q  <= victim;
                        beat_q      <= '0;
                        fill_dead_q <= 1'b0;
                    end
                end
                CS_FILL: begin
                    if (sn_on_fill) fill_dead_q <= 1'b1;
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (&beat_q) state_q <= CS_IDLE;
                    end
                end
                CS_WRITE: begin
                    if (mem_ack) state_q <= CS_IDLE;
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req); // R2

    AST_FILL_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3

    AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_IDLE && cpu_req && cpu_we) |=>
            (mem_req && mem_we && mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata))); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !cpu_ready)); // R1

endmodule

// File: tb/tb_snoop_cache.sv
`timescale 1ns/1ps
module tb_snoop_cache;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we;
    logic [11:0] cpu_addr;
    logic [31:0] cpu_wdata;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        snp_we;
    logic [11:0] snp_addr;

    logic [31:0] mem_model [4096];
    logic [11:0] base;
    int          n_chk = 0;
    int          n_err = 0;
    int          fills = 0;
    int          f0;

    always #4 clk = ~clk;

    snoop_cache dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snp_we(snp_we), .snp_addr(snp_addr)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [11:0] a, input bit exp_hit, input string rq);
        int waitc = 0;
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        while (!cpu_ready) begin
            waitc++;
            @(negedge clk);
        end
        chk((waitc == 0) == exp_hit, rq, waitc, exp_hit ? 0 : 6);
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic cpu_write(input logic [11:0] a, input logic [31:0] d, input string rq);
        @(posedge clk); #1;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(mem_model[a] == d, rq, mem_model[a], d);
    endtask

    task automatic snoop(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        snp_we = 1'b1; snp_addr = a; mem_model[a] = d;
        @(posedge clk); #1;
        snp_we = 1'b0;
    endtask

    // Memory model: read bursts after one idle cycle, writes acknowledged at once.
    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(posedge clk); #1;
            if (!rst && mem_req && !mem_we) begin
                base = mem_addr;
                fills++;
                chk(base[1:0] == 2'b00, "R3 fill address line-aligned", base, {base[11:2], 2'b00});
                @(posedge clk); #1;
                for (int b = 0; b < 4; b++) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_model[base + 12'(b)];
                    @(posedge clk); #1;
                end
                mem_ack = 1'b0;
            end else if (!rst && mem_req && mem_we) begin
                mem_ack = 1'b1;
                @(posedge clk);
                mem_model[mem_addr] = mem_wdata;
                #1 mem_ack = 1'b0;
            end
        end
    end

    // Every-clock comparison of completed reads against the memory model.
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_ready && !cpu_req) chk(1'b0, "R2 ready without request", 1, 0);
            if (cpu_ready && cpu_req && !cpu_we)
                chk(cpu_rdata == mem_model[cpu_addr], "R12 read data matches memory",
                    cpu_rdata, mem_model[cpu_addr]);
        end
    end

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        snp_we = 1'b0; snp_addr = '0;
        for (int i = 0; i < 4096; i++) mem_model[i] = 32'hC0DE0000 | i;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R1 quiet after reset", {cpu_ready, mem_req}, 0);

        f0 = fills;
        cpu_read(12'h041, 1'b0, "R1 first read misses");
        chk(fills - f0 == 1, "R3 one burst per miss", fills - f0, 1);
        cpu_read(12'h043, 1'b1, "R2 hit in filled line");
        cpu_read(12'h040, 1'b1, "R3 word 0 of burst");

        cpu_read(12'h081, 1'b0, "R4 second tag same set misses");
        cpu_read(12'h042, 1'b1, "R4 first way kept");
        cpu_read(12'h081, 1'b1, "R4 second way hits");
        cpu_read(12'h0C1, 1'b0, "R5 third tag misses");
        cpu_read(12'h081, 1'b1, "R5 recent line kept");
        cpu_read(12'h041, 1'b0, "R5 LRU line was evicted");

        cpu_read(12'h014, 1'b0, "R5 setup way 0");
        cpu_read(12'h054, 1'b0, "R5 setup way 1");
        cpu_read(12'h014, 1'b1, "R5 way 0 touched");
        snoop(12'h014, 32'hAAAA0014);
        cpu_read(12'h094, 1'b0, "R5 refill of invalid way");
        cpu_read(12'h054, 1'b1, "R5 valid LRU way not evicted");

        cpu_read(12'h104, 1'b0, "R6 setup");
        snoop(12'h106, 32'h5A5A0106);
        cpu_read(12'h106, 1'b0, "R6 snooped line refetched");
        cpu_read(12'h104, 1'b1, "R6 refetched line hits");

        snoop(12'h144, 32'h11110144);
        snoop(12'h208, 32'h22220208);
        cpu_read(12'h105, 1'b1, "R7 unmatched snoop harmless");

        f0 = fills;
        fork
            cpu_read(12'h30C, 1'b0, "R8 miss with snoop in burst");
            begin
                repeat (2) @(posedge clk);
                snoop(12'h30D, 32'h7777030D);
            end
        join
        chk(fills - f0 == 2, "R8 killed fill refetched", fills - f0, 2);
        cpu_read(12'h30D, 1'b1, "R8 refetched word fresh");

        fork
            cpu_read(12'h30C, 1'b0, "R9 same-cycle snoop forces miss");
            snoop(12'h30C, 32'h9999030C);
        join

        cpu_write(12'h30E, 32'h12345678, "R10 write hit reaches memory");
        cpu_read(12'h30E, 1'b1, "R10 cached word updated");

        cpu_write(12'h40A, 32'hFEED040A, "R10 write miss reaches memory");
        cpu_read(12'h40A, 1'b0, "R11 write miss not allocated");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule